// File: doc/BRIEF.md
# Expansion DMA Register Block

This block is the host-facing register file of a memory-expansion DMA controller. A byte-wide register bus reaches a 32-byte window. The window holds a host address, an expansion address with a bank extension, a transfer length, a command byte, an interrupt mask and an address-control byte. The transfer engine sits outside the block. It reads its configuration from level outputs and receives a one-cycle `go_o` pulse when software writes a command with the execute bit set. When it finishes, it pulses `done_i` and supplies the final addresses, the final length and the status flags to raise.

Each address, bank and length register has a shadow copy. When a transfer completes, the live registers either reload from the shadows (autoload) or take the engine's final values. The writeback is gated per side by the address-control "hold fixed" bits. The block also contains the interrupt pending logic and the read-to-clear behaviour of the status register.

Top module: `xdma_regfile`

## Requirements
- R1: After reset, irq_o is 0 and go_o is 0. Status reads as {pending=0, end-of-block=0, verify-error=0, dram flag=BIG_DRAM, version=CHIP_VER}; with the defaults this is 0x10. Command, addresses and length read 0x00. Bank reads 0xF8, interrupt mask reads 0x1F and address control reads 0x3F.
- R2: Read map by offset:
  - 0x0: status {bit7 pending, bit6 end-of-block, bit5 verify error, bit4 dram flag, bits3:0 version}.
  - 0x1: command.
  - 0x2/0x3: host address low/high.
  - 0x4/0x5: expansion address low/high.
  - 0x6: bank in bits 2:0, with bits 7:3 reading 1.
  - 0x7/0x8: length low/high.
  - 0x9: mask bits 7:5, with bits 4:0 reading 1.
  - 0xA: address control bits 7:6, with bits 5:0 reading 1.
- R3: A host read of status at offset 0x0 clears status bits 7:5 and drops irq_o on the following cycle.
- R4: A byte write to an address, bank or length register stores the byte into the shadow copy. The live register then takes the whole updated shadow value. A high-byte write therefore also restores the live low byte from the shadow.
- R5: Writing the command (offset 0x1) with bit 7 set produces a one-cycle go_o pulse on the next cycle. The command fields drive these outputs: mode_o = bits 1:0 (0 host to expansion, 1 expansion to host, 2 swap, 3 verify) and go_now_o = bit 4. Address control bit 7 drives host_fix_o and bit 6 drives exp_fix_o.
- R6: On done_i with command bit 5 (autoload) set, the host address, expansion address, bank and length all reload from their shadow copies.
- R7: On done_i without autoload, the following writebacks happen:
  - The host address takes done_host_addr_i unless address control bit 7 is set.
  - The expansion address and bank take done_exp_addr_i and done_bank_i unless address control bit 6 is set.
  - The length always takes done_len_i.
- R8: On done_i, status bit 6 is set by done_eob_i and bit 5 by done_verr_i. Command bit 7 is cleared and command bit 4 is set.
- R9: On done_i, an interrupt becomes pending (status bit 7 and irq_o high, held until status is read) only when mask bit 7 is set and one of these holds:
  - done_eob_i with mask bit 6 set;
  - done_verr_i with mask bit 5 set.
- R10: Writing the interrupt mask makes an interrupt pending when the new mask has bit 7 set together with bit 6 while end-of-block is already set, or with bit 5 while verify error is already set.
- R11: Writes to status (offset 0x0) and to offsets 0x0B–0x1F change no register. Reads of offsets 0x0B–0x1F return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_cs_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Interrupt request, level |
| go_o | output | 1 | Start pulse toward the transfer engine |
| go_now_o | output | 1 | Start without waiting for the delayed trigger |
| mode_o | output | 2 | Transfer type |
| host_addr_o | output | 16 | Live host address |
| exp_addr_o | output | 16 | Live expansion address |
| bank_o | output | BANK_W | Live expansion bank |
| len_o | output | 16 | Live transfer length |
| host_fix_o | output | 1 | Host address held fixed |
| exp_fix_o | output | 1 | Expansion address held fixed |
| done_i | input | 1 | Transfer completion pulse |
| done_host_addr_i | input | 16 | Final host address |
| done_exp_addr_i | input | 16 | Final expansion address |
| done_bank_i | input | BANK_W | Final bank |
| done_len_i | input | 16 | Final length |
| done_eob_i | input | 1 | Raise end-of-block |
| done_verr_i | input | 1 | Raise verify error |

## Verification
The assertions assume that the engine never pulses `done_i` in a cycle where the register bus is strobed. Under that assumption, completion updates and software writes or the status read never meet on the same edge. The stimulus keeps every bus access and every completion pulse in separate cycles, one operation per task call. The cycle-accurate model in the bench checks each register's readback, the interrupt level and the go pulse after every operation. The scenarios cover autoload, each fixed-address combination, interrupts that are masked and unmasked, a late mask write, and the half-written restore of a live register from its shadow.

// File: rtl/xdma_rf_pkg.sv
package xdma_rf_pkg;
  localparam int OFS_STATUS = 'h00;
  localparam int OFS_CMD    = 'h01;
  localparam int OFS_HOST_L = 'h02;
  localparam int OFS_HOST_H = 'h03;
  localparam int OFS_EXP_L  = 'h04;
  localparam int OFS_EXP_H  = 'h05;
  localparam int OFS_BANK   = 'h06;
  localparam int OFS_LEN_L  = 'h07;
  localparam int OFS_LEN_H  = 'h08;
  localparam int OFS_MASK   = 'h09;
  localparam int OFS_ACTL   = 'h0A;

  localparam int WORD_W = 16;

  // command bit positions
  localparam int CMD_NOW  = 4;
  localparam int CMD_AUTO = 5;
  localparam int CMD_EXEC = 7;

  // stored mask bits (register bits 7:5)
  localparam int MSK_ALL  = 2;
  localparam int MSK_EOB  = 1;
  localparam int MSK_VERR = 0;

  // stored address-control bits (register bits 7:6)
  localparam int ACTL_HOST = 1;
  localparam int ACTL_EXP  = 0;

  typedef enum logic [1:0] {
    XFER_TO_EXP   = 2'd0,
    XFER_FROM_EXP = 2'd1,
    XFER_SWAP     = 2'd2,
    XFER_VERIFY   = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/xdma_shadow_pair.sv
module xdma_shadow_pair #(
  parameter int WIDTH = 16,
  localparam int NB = (WIDTH + 7) / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NB-1:0]    byte_we_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             reload_i,
  input  logic             wb_i,
  input  logic [WIDTH-1:0] wb_val_i,
  output logic [WIDTH-1:0] live_o,
  output logic [WIDTH-1:0] shadow_o
);
  logic [WIDTH-1:0] live_q, shadow_q, shadow_n;

  always_comb begin
    for (int i = 0; i < WIDTH; i++)
      shadow_n[i] = byte_we_i[i/8] ? wr_data_i[i] : shadow_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q   <= '0;
      shadow_q <= '0;
    end else if (|byte_we_i) begin
      // live copy follows the complete shadow, not just the written byte
      shadow_q <= shadow_n;
      live_q   <= shadow_n;
    end else if (reload_i) begin
      live_q <= shadow_q;
    end else if (wb_i) begin
      live_q <= wb_val_i;
    end
  end

  assign live_o   = live_q;
  assign shadow_o = shadow_q;

  AST_RELOAD_FROM_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && !(|byte_we_i)) |=> (live_o == $past(shadow_o)));  // R6
  AST_SHADOW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|byte_we_i) |=> $stable(shadow_o));  // R4
endmodule

// File: rtl/xdma_irq_ctrl.sv
module xdma_irq_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       done_i,
  input  logic       set_eob_i,
  input  logic       set_verr_i,
  input  logic [2:0] mask_cur_i,
  input  logic       mask_wr_i,
  input  logic [2:0] mask_new_i,
  output logic       eob_o,
  output logic       verr_o,
  output logic       irq_o
);
  import xdma_rf_pkg::*;

  logic eob_q, verr_q, pend_q;
  logic hit_done, hit_mask;

  assign hit_done = done_i &&
    ((set_eob_i  && mask_cur_i[MSK_ALL] && mask_cur_i[MSK_EOB]) ||
     (set_verr_i && mask_cur_i[MSK_ALL] && mask_cur_i[MSK_VERR]));
  assign hit_mask = mask_wr_i &&
    ((eob_q  && mask_new_i[MSK_ALL] && mask_new_i[MSK_EOB]) ||
     (verr_q && mask_new_i[MSK_ALL] && mask_new_i[MSK_VERR]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eob_q  <= 1'b0;
      verr_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      eob_q  <= (eob_q  & ~clr_i) | (done_i & set_eob_i);
      verr_q <= (verr_q & ~clr_i) | (done_i & set_verr_i);
      pend_q <= (pend_q & ~clr_i) | hit_done | hit_mask;
    end
  end

  assign eob_o  = eob_q;
  assign verr_o = verr_q;
  assign irq_o  = pend_q;

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !done_i && !mask_wr_i) |=> (!irq_o && !eob_o && !verr_o));  // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done_i || mask_wr_i));  // R9
  AST_EOB_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && set_eob_i) |=> eob_o);  // R8
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);  // R10
endmodule

// File: rtl/xdma_regfile.sv
module xdma_regfile
  import xdma_rf_pkg::*;
#(
  parameter int         ADDR_W   = 5,
  parameter int         BANK_W   = 3,
  parameter logic [3:0] CHIP_VER = 4'h0,
  parameter logic       BIG_DRAM = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_cs_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o,
  output logic              go_o,
  output logic              go_now_o,
  output logic [1:0]        mode_o,
  output logic [15:0]       host_addr_o,
  output logic [15:0]       exp_addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [15:0]       len_o,
  output logic              host_fix_o,
  output logic              exp_fix_o,
  input  logic              done_i,
  input  logic [15:0]       done_host_addr_i,
  input  logic [15:0]       done_exp_addr_i,
  input  logic [BANK_W-1:0] done_bank_i,
  input  logic [15:0]       done_len_i,
  input  logic              done_eob_i,
  input  logic              done_verr_i
);
  localparam int BANK_PAD = 8 - BANK_W;

  logic bus_wr, bus_rd;
  logic [7:0] cmd_q;
  logic [2:0] msk_q;
  logic [1:0] actl_q;
  logic go_q;
  logic autold, wb_host, wb_exp, wb_len, reload;
  logic [WORD_W-1:0] host_sh, exp_sh, len_sh;
  logic [BANK_W-1:0] bank_sh;
  logic st_eob, st_verr;

  assign bus_wr = reg_cs_i & reg_we_i;
  assign bus_rd = reg_cs_i & ~reg_we_i;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      msk_q  <= '0;
      actl_q <= '0;
      go_q   <= 1'b0;
    end else begin
      go_q <= bus_wr && at(reg_addr_i, OFS_CMD) && reg_wdata_i[CMD_EXEC];
      if (bus_wr && at(reg_addr_i, OFS_CMD)) cmd_q <= reg_wdata_i;
      else if (done_i) begin
        cmd_q[CMD_EXEC] <= 1'b0;
        cmd_q[CMD_NOW]  <= 1'b1;
      end
      if (bus_wr && at(reg_addr_i, OFS_MASK)) msk_q  <= reg_wdata_i[7:5];
      if (bus_wr && at(reg_addr_i, OFS_ACTL)) actl_q <= reg_wdata_i[7:6];
    end
  end

  assign autold  = cmd_q[CMD_AUTO];
  assign reload  = done_i & autold;
  assign wb_len  = done_i & ~autold;
  assign wb_host = wb_len & ~actl_q[ACTL_HOST];
  assign wb_exp  = wb_len & ~actl_q[ACTL_EXP];

  xdma_shadow_pair #(.WIDTH(WORD_W)) u_host (
    .clk_i, .rst_ni,
    .byte_we_i ({bus_wr & at(reg_addr_i, OFS_HOST_H), bus_wr & at(reg_addr_i, OFS_HOST_L)}),
    .wr_data_i ({2{reg_wdata_i}}),
    .reload_i  (reload),
    .wb_i      (wb_host),
    .wb_val_i  (done_host_addr_i),
    .live_o    (host_addr_o),
    .shadow_o  (host_sh)
  );

  xdma_shadow_pair #(.WIDTH(WORD_W)) u_exp (
    .clk_i, .rst_ni,
    .byte_we_i ({bus_wr & at(reg_addr_i, OFS_EXP_H), bus_wr & at(reg_addr_i, OFS_EXP_L)}),
    .wr_data_i ({2{reg_wdata_i}}),
    .reload_i  (reload),
    .wb_i      (wb_exp),
    .wb_val_i  (done_exp_addr_i),
    .live_o    (exp_addr_o),
    .shadow_o  (exp_sh)
  );

  xdma_shadow_pair #(.WIDTH(BANK_W)) u_bank (
    .clk_i, .rst_ni,
    .byte_we_i (bus_wr & at(reg_addr_i, OFS_BANK)),
    .wr_data_i (reg_wdata_i[BANK_W-1:0]),
    .reload_i  (reload),
    .wb_i      (wb_exp),
    .wb_val_i  (done_bank_i),
    .live_o    (bank_o),
    .shadow_o  (bank_sh)
  );

  xdma_shadow_pair #(.WIDTH(WORD_W)) u_len (
    .clk_i, .rst_ni,
    .byte_we_i ({bus_wr & at(reg_addr_i, OFS_LEN_H), bus_wr & at(reg_addr_i, OFS_LEN_L)}),
    .wr_data_i ({2{reg_wdata_i}}),
    .reload_i  (reload),
    .wb_i      (wb_len),
    .wb_val_i  (done_len_i),
    .live_o    (len_o),
    .shadow_o  (len_sh)
  );

  xdma_irq_ctrl u_irq (
    .clk_i, .rst_ni,
    .clr_i      (bus_rd & at(reg_addr_i, OFS_STATUS)),
    .done_i,
    .set_eob_i  (done_eob_i),
    .set_verr_i (done_verr_i),
    .mask_cur_i (msk_q),
    .mask_wr_i  (bus_wr & at(reg_addr_i, OFS_MASK)),
    .mask_new_i (reg_wdata_i[7:5]),
    .eob_o      (st_eob),
    .verr_o     (st_verr),
    .irq_o
  );

  always_comb begin
    case (reg_addr_i)
      ADDR_W'(OFS_STATUS): reg_rdata_o = {irq_o, st_eob, st_verr, BIG_DRAM, CHIP_VER};
      ADDR_W'(OFS_CMD):    reg_rdata_o = cmd_q;
      ADDR_W'(OFS_HOST_L): reg_rdata_o = host_addr_o[7:0];
      ADDR_W'(OFS_HOST_H): reg_rdata_o = host_addr_o[15:8];
      ADDR_W'(OFS_EXP_L):  reg_rdata_o = exp_addr_o[7:0];
      ADDR_W'(OFS_EXP_H):  reg_rdata_o = exp_addr_o[15:8];
      ADDR_W'(OFS_BANK):   reg_rdata_o = {{BANK_PAD{1'b1}}, bank_o};
      ADDR_W'(OFS_LEN_L):  reg_rdata_o = len_o[7:0];
      ADDR_W'(OFS_LEN_H):  reg_rdata_o = len_o[15:8];
      ADDR_W'(OFS_MASK):   reg_rdata_o = {msk_q, 5'h1F};
      ADDR_W'(OFS_ACTL):   reg_rdata_o = {actl_q, 6'h3F};
      default:             reg_rdata_o = 8'hFF;
    endcase
  end

  assign go_o       = go_q;
  assign go_now_o   = cmd_q[CMD_NOW];
  assign mode_o     = cmd_q[1:0];
  assign host_fix_o = actl_q[ACTL_HOST];
  assign exp_fix_o  = actl_q[ACTL_EXP];

  AST_CMD_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !reg_cs_i) |=> (!cmd_q[CMD_EXEC] && cmd_q[CMD_NOW]));  // R8
  AST_AUTOLOAD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && autold && !reg_cs_i) |=> (len_o == $past(len_sh) && host_addr_o == $past(host_sh)
                                         && exp_addr_o == $past(exp_sh) && bank_o == $past(bank_sh)));  // R6
  AST_HOST_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !autold && actl_q[ACTL_HOST] && !reg_cs_i) |=> $stable(host_addr_o));  // R7
  AST_LEN_WRITEBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !autold && !reg_cs_i) |=> (len_o == $past(done_len_i)));  // R7
  AST_GO_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> $past(bus_wr && at(reg_addr_i, OFS_CMD)));  // R5
  AST_UNUSED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr && !done_i && (reg_addr_i > ADDR_W'(OFS_ACTL) || at(reg_addr_i, OFS_STATUS)))
      |=> ($stable(cmd_q) && $stable(msk_q) && $stable(actl_q) && $stable(host_addr_o)
           && $stable(len_o) && $stable(irq_o)));  // R11
endmodule

// File: tb/xdma_regfile_test.sv
module xdma_regfile_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic irq, go, go_now, hfix, efix;
  logic [1:0] mode;
  logic [15:0] host, expa, len;
  logic [2:0] bank;
  logic dn = 1'b0, d_eob = 1'b0, d_verr = 1'b0;
  logic [15:0] d_host = '0, d_exp = '0, d_len = '0;
  logic [2:0] d_bank = '0;

  always #4 clk = ~clk;

  xdma_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_cs_i(cs), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .irq_o(irq), .go_o(go), .go_now_o(go_now),
    .mode_o(mode), .host_addr_o(host), .exp_addr_o(expa), .bank_o(bank), .len_o(len),
    .host_fix_o(hfix), .exp_fix_o(efix), .done_i(dn), .done_host_addr_i(d_host),
    .done_exp_addr_i(d_exp), .done_bank_i(d_bank), .done_len_i(d_len),
    .done_eob_i(d_eob), .done_verr_i(d_verr)
  );

  // behavioural reference
  int unsigned m_h, m_hs, m_e, m_es, m_b, m_bs, m_l, m_ls;
  int unsigned m_cmd, m_mask, m_actl;
  bit m_eob, m_verr, m_irq, m_go;
  int vectors = 0, miscompares = 0;
  string cur_req = "R1";
  bit finished = 0;

  function automatic int unsigned exp_read(input int unsigned a);
    case (a)
      0: return (m_irq << 7) | (m_eob << 6) | (m_verr << 5) | 'h10;
      1: return m_cmd;
      2: return m_h & 'hFF;
      3: return m_h >> 8;
      4: return m_e & 'hFF;
      5: return m_e >> 8;
      6: return 'hF8 | m_b;
      7: return m_l & 'hFF;
      8: return m_l >> 8;
      9: return m_mask | 'h1F;
      10: return m_actl | 'h3F;
      default: return 'hFF;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_hs = 0; m_e = 0; m_es = 0; m_b = 0; m_bs = 0; m_l = 0; m_ls = 0;
      m_cmd = 0; m_mask = 0; m_actl = 0; m_eob = 0; m_verr = 0; m_irq = 0; m_go = 0;
    end else begin
      m_go = cs && we && addr == 1 && wd[7];
      if (cs && we) begin
        case (addr)
          1: m_cmd = wd;
          2: begin m_hs = (m_hs & 'hFF00) | wd; m_h = m_hs; end
          3: begin m_hs = (m_hs & 'h00FF) | (wd << 8); m_h = m_hs; end
          4: begin m_es = (m_es & 'hFF00) | wd; m_e = m_es; end
          5: begin m_es = (m_es & 'h00FF) | (wd << 8); m_e = m_es; end
          6: begin m_bs = wd & 7; m_b = m_bs; end
          7: begin m_ls = (m_ls & 'hFF00) | wd; m_l = m_ls; end
          8: begin m_ls = (m_ls & 'h00FF) | (wd << 8); m_l = m_ls; end
          9: begin
               m_mask = wd & 'hE0;
               if (wd[7] && ((wd[6] && m_eob) || (wd[5] && m_verr))) m_irq = 1;
             end
          10: m_actl = wd & 'hC0;
          default: ;
        endcase
      end
      if (cs && !we && addr == 0) begin m_eob = 0; m_verr = 0; m_irq = 0; end
      if (dn) begin
        if (m_cmd & 'h20) begin m_h = m_hs; m_e = m_es; m_b = m_bs; m_l = m_ls; end
        else begin
          if (!(m_actl & 'h80)) m_h = d_host;
          if (!(m_actl & 'h40)) begin m_e = d_exp; m_b = d_bank; end
          m_l = d_len;
        end
        if (d_eob) m_eob = 1;
        if (d_verr) m_verr = 1;
        if ((m_mask & 'h80) && ((d_eob && (m_mask & 'h40)) || (d_verr && (m_mask & 'h20)))) m_irq = 1;
        m_cmd = (m_cmd & 'h7F) | 'h10;
      end
    end
  end

  task automatic chk(input string nm, input int unsigned act, input int unsigned expv);
    if (act != expv) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, nm, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vectors++;
      chk("rdata", rdata, exp_read(addr));
      chk("irq", irq, m_irq);
      chk("go", go, m_go);
      chk("go_now", go_now, (m_cmd >> 4) & 1);
      chk("mode", mode, m_cmd & 3);
      chk("host_addr", host, m_h);
      chk("exp_addr", expa, m_e);
      chk("bank", bank, m_b);
      chk("len", len, m_l);
      chk("host_fix", hfix, (m_actl >> 7) & 1);
      chk("exp_fix", efix, (m_actl >> 6) & 1);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    cs = 1; we = 1; addr = a; wd = d;
    @(posedge clk); #2;
    cs = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(posedge clk); #2;
    cs = 1; we = 0; addr = a;
    @(posedge clk); #2;
    cs = 0;
  endtask

  task automatic fin(input logic [15:0] h, input logic [15:0] e, input logic [2:0] b,
                     input logic [15:0] l, input logic eob, input logic verr);
    @(posedge clk); #2;
    dn = 1; d_host = h; d_exp = e; d_bank = b; d_len = l; d_eob = eob; d_verr = verr;
    @(posedge clk); #2;
    dn = 0; d_eob = 0; d_verr = 0;
  endtask

  task automatic read_all();
    for (int a = 0; a < 32; a++) rd(5'(a));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cur_req = "R1"; rd(5'h00); rd(5'h06); rd(5'h09); rd(5'h0A);
    cur_req = "R2"; read_all();

    cur_req = "R4";
    wr(5'h02, 8'h34); wr(5'h03, 8'h12);
    wr(5'h04, 8'h78); wr(5'h05, 8'h56);
    wr(5'h06, 8'hFD);
    wr(5'h07, 8'h10); wr(5'h08, 8'h00);
    read_all();

    cur_req = "R5";
    wr(5'h0A, 8'h00); wr(5'h09, 8'h00);
    wr(5'h01, 8'h90);
    wr(5'h01, 8'h03);
    wr(5'h01, 8'h82);

    cur_req = "R7";
    fin(16'h1244, 16'h5688, 3'd6, 16'h0001, 1'b1, 1'b0);
    cur_req = "R8"; rd(5'h01); rd(5'h00);
    cur_req = "R3"; rd(5'h00);

    cur_req = "R4"; wr(5'h03, 8'h22); read_all();

    cur_req = "R6";
    wr(5'h01, 8'hA1);
    fin(16'hAAAA, 16'hBBBB, 3'd1, 16'h0CCC, 1'b1, 1'b0);
    read_all();

    cur_req = "R7";
    wr(5'h01, 8'h82); wr(5'h0A, 8'hC0);
    fin(16'h1111, 16'h2222, 3'd3, 16'h0333, 1'b1, 1'b0);
    wr(5'h0A, 8'h80);
    fin(16'h4444, 16'h5555, 3'd2, 16'h0666, 1'b0, 1'b1);
    wr(5'h0A, 8'h40);
    fin(16'h7777, 16'h8888, 3'd7, 16'h0999, 1'b1, 1'b0);
    read_all();

    cur_req = "R9";
    wr(5'h0A, 8'h00); rd(5'h00);
    wr(5'h09, 8'hE0);
    fin(16'h0100, 16'h0200, 3'd0, 16'h0000, 1'b1, 1'b0);
    rd(5'h00);
    cur_req = "R3"; rd(5'h00);
    cur_req = "R9";
    wr(5'h09, 8'h60);
    fin(16'h0101, 16'h0201, 3'd0, 16'h0000, 1'b1, 1'b1);
    rd(5'h00);
    wr(5'h09, 8'hC0);
    rd(5'h00);
    fin(16'h0102, 16'h0202, 3'd0, 16'h0000, 1'b0, 1'b1);
    rd(5'h00);
    wr(5'h09, 8'hA0);
    fin(16'h0103, 16'h0203, 3'd0, 16'h0000, 1'b0, 1'b1);
    rd(5'h00);

    cur_req = "R10";
    wr(5'h09, 8'h00);
    fin(16'h0104, 16'h0204, 3'd0, 16'h0000, 1'b1, 1'b0);
    wr(5'h09, 8'hA0);
    wr(5'h09, 8'hC0);
    rd(5'h00);
    wr(5'h09, 8'hC0);
    wr(5'h09, 8'h00);
    fin(16'h0105, 16'h0205, 3'd0, 16'h0000, 1'b0, 1'b1);
    wr(5'h09, 8'hA0);
    rd(5'h00);

    cur_req = "R11";
    wr(5'h00, 8'hFF);
    for (int a = 11; a < 32; a++) wr(5'(a), 8'hAA);
    read_all();

    repeat (2) @(posedge clk);
    summary();
  end
endmodule